// File: doc/BRIEF.md
# DRAM Periodic Refresh Scheduler

This block tells a DRAM controller's command arbiter when a refresh is due. A free-running interval timer, counted in clock cycles from a clock-period parameter, adds one refresh to a backlog at every interval. When the high-temperature input is set, the interval halves. The arbiter sees a request whenever the backlog is non-empty. It may postpone service, up to a fixed backlog depth. At that depth the request is flagged urgent and must be served next. After each accepted refresh the request is held off for the refresh recovery time, so no further refresh is asked for while the device is still recovering.

The block also tracks the temperature range. Every change of range raises a mode-register-update request. That request stays up until the controller confirms that the new internal self-refresh rate has been written. While it is outstanding, self-refresh entry is reported as not allowed.

With the default parameters (4 ns clock, 7.8 µs interval, 127.5 ns recovery) the interval is 1950 cycles, or 975 cycles when hot, and the recovery window is 32 cycles. Eight thousand intervals of 7.8 µs fit in a 64 ms retention window.

Top module: `refresh_sched`

## Requirements
- R1: In reset and right after it, `ref_req_o`, `ref_urgent_o` and `mr_upd_req_o` are 0, `pending_o` is 0 and `sr_allow_o` is 1.
- R2: With the temperature range cool, `pending_o` rises by one every NORM_CYC = TREFI_PS / CLK_PERIOD_PS cycles when no refresh is granted.
- R3: With the temperature range hot, the interval between backlog increments is HOT_CYC = NORM_CYC / 2 cycles.
- R4: `pending_o` never exceeds MAX_PEND and stays there when further intervals expire without a grant. `ref_urgent_o` is 1 exactly when `pending_o` equals MAX_PEND.
- R5: `ref_req_o` is 1 exactly when `pending_o` is non-zero and no recovery window is running.
- R6: A grant in a cycle with `ref_req_o` high lowers `pending_o` by one at the next edge. A grant while `ref_req_o` is low has no effect on `pending_o`.
- R7: After an accepted grant, `ref_req_o` stays low for exactly TRFC_CYC cycles (TRFC_PS / CLK_PERIOD_PS rounded up) and then returns if backlog remains.
- R8: A change of `hot_i` raises `mr_upd_req_o` at the next edge. It holds until `mr_upd_done_i` is sampled high. A range change wins over a simultaneous done.
- R9: `sr_allow_o` is 0 while a mode-register update is outstanding and 1 otherwise.
- R10: An accepted grant on the same edge as an interval expiry leaves `pending_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hot_i | input | 1 | Case temperature in the high range (1) or normal range (0) |
| ref_gnt_i | input | 1 | Arbiter accepts the refresh request this cycle |
| mr_upd_done_i | input | 1 | Mode-register update for the current range has been issued |
| ref_req_o | output | 1 | Refresh wanted |
| ref_urgent_o | output | 1 | Backlog full; refresh must be served next |
| pending_o | output | PW | Number of refreshes owed |
| mr_upd_req_o | output | 1 | Mode-register update to the current range outstanding |
| sr_allow_o | output | 1 | Self-refresh entry permitted |

## Verification
The interval is measured as the gap between successive backlog increments. This is done in the cool range, in the hot range, and again after returning to cool, which separates the two rates and shows the timer reloads cleanly across a switch. Grants are placed at chosen timer phases: one cycle after an expiry, which gives a pure decrement and then the recovery window, and exactly on an expiry, which gives no net change. A stray grant during recovery must leave the backlog alone. The backlog is run up to saturation with urgency watched on every cycle, and then drained. Both range transitions are used to check the update request, its hold and its release.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
   // rounding-up integer division for time-to-cycle conversion
   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction
endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
   parameter int NORM_CYC = 1950,
   parameter int HOT_CYC  = 975
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hot_sel,
   output logic tick_o
);
   localparam int CW = $clog2(NORM_CYC);
   localparam logic [CW-1:0] NORM_LAST = CW'(NORM_CYC - 1);
   localparam logic [CW-1:0] HOT_LAST  = CW'(HOT_CYC - 1);

   logic [CW-1:0] cnt_q;

   // >= so a switch to the short interval mid-count expires at once
   assign tick_o = hot_sel ? (cnt_q >= HOT_LAST) : (cnt_q >= NORM_LAST);

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt_q <= '0;
      else if (tick_o) cnt_q <= '0;
      else             cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/ref_backlog.sv
module ref_backlog #(
   parameter int MAX_PEND = 8,
   parameter int PW       = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc_i,
   input  logic          dec_i,
   output logic [PW-1:0] pend_o,
   output logic          full_o
);
   localparam logic [PW-1:0] MAX_V = PW'(MAX_PEND);

   logic [PW-1:0] pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= '0;
      else begin
         unique case ({inc_i, dec_i})
            2'b10:   if (pend_q != MAX_V) pend_q <= pend_q + 1'b1;
            2'b01:   if (pend_q != '0)    pend_q <= pend_q - 1'b1;
            default: pend_q <= pend_q;
         endcase
      end
   end

   assign pend_o = pend_q;
   assign full_o = (pend_q == MAX_V);
endmodule

// File: rtl/ref_recovery.sv
module ref_recovery #(
   parameter int TRFC_CYC = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o
);
   generate
      if (TRFC_CYC == 0) begin : g_none
         logic unused_in;
         assign unused_in = start_i ^ clk ^ rst_n;
         assign busy_o    = 1'b0;
      end else begin : g_count
         localparam int RW = $clog2(TRFC_CYC + 1);
         localparam logic [RW-1:0] LOAD_V = RW'(TRFC_CYC);
         logic [RW-1:0] left_q;
         always_ff @(posedge clk) begin
            if (!rst_n)             left_q <= '0;
            else if (start_i)       left_q <= LOAD_V;
            else if (left_q != '0)  left_q <= left_q - 1'b1;
         end
         assign busy_o = (left_q != '0);
      end
   endgenerate
endmodule

// File: rtl/ref_temp_track.sv
module ref_temp_track (
   input  logic clk,
   input  logic rst_n,
   input  logic hot_i,
   input  logic done_i,
   output logic range_o,
   output logic mr_req_o,
   output logic sr_allow_o
);
   logic range_q, mr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         range_q <= 1'b0;
         mr_q    <= 1'b0;
      end else if (range_q != hot_i) begin
         range_q <= hot_i;
         mr_q    <= 1'b1;
      end else if (done_i) begin
         mr_q    <= 1'b0;
      end
   end

   assign range_o    = range_q;
   assign mr_req_o   = mr_q;
   assign sr_allow_o = ~mr_q;
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
   parameter int CLK_PERIOD_PS = 4000,
   parameter int TREFI_PS      = 7_800_000,
   parameter int TRFC_PS       = 127_500,
   parameter int MAX_PEND      = 8,
   localparam int PW           = $clog2(MAX_PEND + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hot_i,
   input  logic          ref_gnt_i,
   input  logic          mr_upd_done_i,
   output logic          ref_req_o,
   output logic          ref_urgent_o,
   output logic [PW-1:0] pending_o,
   output logic          mr_upd_req_o,
   output logic          sr_allow_o
);
   import refresh_pkg::*;

   localparam int NORM_CYC = TREFI_PS / CLK_PERIOD_PS;
   localparam int HOT_CYC  = NORM_CYC / 2;
   localparam int TRFC_CYC = ceil_div(TRFC_PS, CLK_PERIOD_PS);

   initial begin
      if (CLK_PERIOD_PS < 1) $error("clock period must be positive");
      if (HOT_CYC < 1)       $error("refresh interval too short for clock");
      if (MAX_PEND < 1)      $error("backlog depth must be at least one");
   end

   logic range_hot, tick, busy, accept;

   assign accept = ref_req_o & ref_gnt_i;

   ref_temp_track u_temp (
      .clk(clk), .rst_n(rst_n), .hot_i(hot_i), .done_i(mr_upd_done_i),
      .range_o(range_hot), .mr_req_o(mr_upd_req_o), .sr_allow_o(sr_allow_o)
   );

   ref_interval_timer #(.NORM_CYC(NORM_CYC), .HOT_CYC(HOT_CYC)) u_timer (
      .clk(clk), .rst_n(rst_n), .hot_sel(range_hot), .tick_o(tick)
   );

   ref_backlog #(.MAX_PEND(MAX_PEND), .PW(PW)) u_backlog (
      .clk(clk), .rst_n(rst_n), .inc_i(tick), .dec_i(accept),
      .pend_o(pending_o), .full_o(ref_urgent_o)
   );

   ref_recovery #(.TRFC_CYC(TRFC_CYC)) u_recov (
      .clk(clk), .rst_n(rst_n), .start_i(accept), .busy_o(busy)
   );

   assign ref_req_o = (pending_o != '0) & ~busy;
endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
   parameter int MAX_PEND = 8,
   parameter int PW       = 4,
   parameter int TRFC_CYC = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          hot_i,
   input logic          ref_gnt_i,
   input logic          mr_upd_done_i,
   input logic          ref_req_o,
   input logic          ref_urgent_o,
   input logic [PW-1:0] pending_o,
   input logic          mr_upd_req_o,
   input logic          sr_allow_o
);
   localparam logic [PW-1:0] MAX_V = PW'(MAX_PEND);
   localparam logic HAS_REC = (TRFC_CYC > 0);

   AST_PEND_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      pending_o <= MAX_V); // R4
   AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (pending_o == MAX_V && !ref_gnt_i) |=> pending_o == MAX_V); // R4
   AST_PEND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (pending_o <= $past(pending_o) + 1'b1)); // R2
   AST_GNT_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_req_o && ref_gnt_i) |=> pending_o <= $past(pending_o)); // R6
   AST_GNT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (!ref_req_o && ref_gnt_i) |=> pending_o >= $past(pending_o)); // R6
   AST_RECOV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (HAS_REC && ref_req_o && ref_gnt_i) |=> !ref_req_o); // R7
   AST_MR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mr_upd_req_o && !mr_upd_done_i) |=> mr_upd_req_o); // R8
   AST_MR_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && hot_i != $past(hot_i)) |=> mr_upd_req_o); // R8
   AST_SR_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && hot_i != $past(hot_i)) |=> !sr_allow_o); // R9
   AST_URGENT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      ref_urgent_o |-> ref_req_o || $past(ref_req_o && ref_gnt_i) || !$past(rst_n) || (pending_o == MAX_V)); // R4
endmodule

bind refresh_sched refresh_sched_chk #(.MAX_PEND(MAX_PEND), .PW(PW), .TRFC_CYC(TRFC_CYC)) u_chk (.*);

// File: tb/tb_refresh_sched.sv
module tb_refresh_sched;
   localparam int CLK_PS   = 4000;
   localparam int TREFI    = 40000;   // 10 cycles cool
   localparam int TRFC     = 12000;   // 3 cycles
   localparam int MAXP     = 8;
   localparam int PW       = $clog2(MAXP + 1);
   localparam int NORM     = TREFI / CLK_PS;
   localparam int HOT      = NORM / 2;
   localparam int TRFC_C   = (TRFC + CLK_PS - 1) / CLK_PS;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hot = 1'b0, gnt = 1'b0, done = 1'b0;
   logic req, urg, mreq, sra;
   logic [PW-1:0] pend;

   int n_run = 0, n_fail = 0;

   always #2ns clk = ~clk;

   refresh_sched #(.CLK_PERIOD_PS(CLK_PS), .TREFI_PS(TREFI), .TRFC_PS(TRFC),
                   .MAX_PEND(MAXP)) dut (
      .clk(clk), .rst_n(rst_n), .hot_i(hot), .ref_gnt_i(gnt),
      .mr_upd_done_i(done), .ref_req_o(req), .ref_urgent_o(urg),
      .pending_o(pend), .mr_upd_req_o(mreq), .sr_allow_o(sra)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // cycles until pending changes, sampled at falling edges
   task automatic wait_change(output int gap);
      logic [PW-1:0] last;
      last = pend;
      gap = 0;
      do begin
         @(negedge clk);
         gap++;
      end while (pend == last && gap < 200);
   endtask

   initial begin
      #400us;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      int gap, p0, low, mism;
      repeat (3) @(negedge clk);
      chk("R1 req", int'(req), 0);
      chk("R1 pending", int'(pend), 0);
      chk("R1 mr req", int'(mreq), 0);
      chk("R1 sr allow", int'(sra), 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 urgent after reset", int'(urg), 0);

      // R2: cool interval
      wait_change(gap);
      wait_change(gap);
      chk("R2 cool gap", gap, NORM);
      chk("R5 req with backlog", int'(req), 1);

      // R6/R7: grant one cycle after expiry
      p0 = int'(pend);
      gnt = 1'b1; @(negedge clk); gnt = 1'b0;
      chk("R6 accepted grant", int'(pend), p0 - 1);
      low = 1;
      gnt = 1'b1; @(negedge clk); gnt = 1'b0;   // stray grant in recovery
      chk("R6 grant ignored when req low", int'(pend), p0 - 1);
      if (!req) low++;
      while (!req && low < 20) begin @(negedge clk); if (!req) low++; end
      chk("R7 recovery length", low, TRFC_C);

      // R10: grant exactly at expiry
      wait_change(gap);
      p0 = int'(pend);
      repeat (NORM - 1) @(negedge clk);
      gnt = 1'b1; @(negedge clk); gnt = 1'b0;
      chk("R10 grant on expiry", int'(pend), p0);

      // R4: saturation and urgency
      mism = 0;
      for (int i = 0; i < 150 && pend != PW'(MAXP); i++) begin
         @(negedge clk);
         if (urg != (pend == PW'(MAXP))) mism++;
      end
      chk("R4 reached max", int'(pend), MAXP);
      for (int i = 0; i < 3 * NORM; i++) begin
         @(negedge clk);
         if (urg != (pend == PW'(MAXP))) mism++;
      end
      chk("R4 saturated", int'(pend), MAXP);
      chk("R4 urgent tracks full", mism, 0);

      // drain
      for (int i = 0; i < 300 && pend != '0; i++) begin
         if (req) begin gnt = 1'b1; @(negedge clk); gnt = 1'b0; end
         else @(negedge clk);
      end
      chk("R5 drained", int'(pend), 0);
      chk("R5 no req when empty", int'(req), 0);

      // R8/R9/R3: go hot
      hot = 1'b1; @(negedge clk);
      chk("R8 update raised", int'(mreq), 1);
      chk("R9 self-refresh blocked", int'(sra), 0);
      repeat (4) @(negedge clk);
      chk("R8 update held", int'(mreq), 1);
      wait_change(gap);
      wait_change(gap);
      chk("R3 hot gap", gap, HOT);
      done = 1'b1; @(negedge clk); done = 1'b0;
      chk("R8 update cleared", int'(mreq), 0);
      chk("R9 self-refresh allowed", int'(sra), 1);

      // back to cool
      hot = 1'b0; @(negedge clk);
      chk("R8 update on cooling", int'(mreq), 1);
      done = 1'b1; @(negedge clk); done = 1'b0;
      chk("R9 allowed after cooling update", int'(sra), 1);
      wait_change(gap);
      wait_change(gap);
      chk("R2 cool gap after return", gap, NORM);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule